// File: doc/BRIEF.md
# Limit-Based Write-Allocate Qualifier

This block decides, once per external write bus cycle, whether the pending cacheable write may allocate a line in the data cache. It holds a 9-bit write-handling control word. The word carries an allocate ceiling counted in 4-Mbyte granules, a switch that opens the 15-to-16-Mbyte region to allocation, and a switch that turns on bus-based cacheability detection. When detection is on, the block samples the active-low cache-enable pin during the write cycle. It takes that sample on the first clock edge at which burst-ready or next-address is seen low.

The address test and the sampled cache-enable are two separate sources of approval. Either one can permit allocation. The legacy window from 0x000A_0000 to 0x000F_FFFF is always refused. The verdict is registered and presented with a one-cycle valid pulse after the edge that ends the cycle. The cache and line-fill logic that consume this verdict sit outside the block.

Top module: `wr_alloc_qualifier`

## Requirements
- R1: After reset the control word is all zeros, `alloc_permit` and `permit_valid` are 0, and a write that presents an asserted cache-enable is refused.
- R2: A pulse on `cfg_we` loads `cfg_wdata` into the control word at that clock edge. Bit 8 is detection enable, bits 7:1 are the ceiling in 4-Mbyte units, and bit 0 opens the 15–16 MB region. The new word governs every cycle that ends at a later edge.
- R3: With a non-zero ceiling L, an address below L×4 MB passes the address test, and an address at or above L×4 MB fails it.
- R4: A ceiling of zero makes the address test fail for every address.
- R5: With bit 0 clear, addresses 0x00F0_0000 to 0x00FF_FFFF fail the address test. With bit 0 set, they pass if they are below the ceiling. Bit 0 has no effect when the ceiling is below 16 MB.
- R6: A write to 0x000A_0000 through 0x000F_FFFF is never permitted, whatever the control word and cache-enable are. The addresses just outside this window behave normally.
- R7: When detection is enabled, cache-enable (active low) is captured on the first edge of the write cycle where burst-ready or next-address is low. Later changes of the pin in that cycle are ignored. When detection is disabled, the pin has no effect.
- R8: The write is permitted when the address test passes or the captured cache-enable is asserted.
- R9: A cycle starts when `cyc_start` is accepted and ends on the first edge with burst-ready low. `permit_valid` is high for exactly the one cycle after that edge, and `alloc_permit` holds its verdict until the next cycle ends. The captured cache-enable is cleared when each new cycle starts.
- R10: A `cyc_start` that arrives while a cycle is in progress is ignored, and the original address is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load strobe for the control word |
| cfg_wdata | input | 9 | Control word value |
| cyc_start | input | 1 | A write cycle begins; `cyc_addr` is valid |
| cyc_addr | input | 32 | Byte address of the write |
| burst_rdy_n | input | 1 | Burst-ready strobe, active low; ends the cycle |
| next_addr_n | input | 1 | Next-address strobe, active low |
| cache_en_n | input | 1 | Chipset cache-enable, active low |
| alloc_permit | output | 1 | Registered allocate verdict of the last finished cycle |
| permit_valid | output | 1 | One-cycle pulse when a new verdict is presented |

## Verification
Several properties are checked on every clock. The valid pulse never lasts two cycles. A verdict for an address in the legacy window is never a permit. A zero ceiling never yields a passing address test. Once cache-enable has been captured, it stays unchanged for the rest of the cycle. A start request during an active cycle leaves the held address untouched. Other behaviour can only be shown by the bench's scenarios, which compare against a behavioural model on every clock: the exact ceiling boundary, the 15–16 MB region in its open, closed and ignored cases, the choice of sampling edge when next-address comes before burst-ready, and the clearing of the capture between cycles.

// File: rtl/wa_pkg.sv
package wa_pkg;
    localparam int ADDR_W     = 32;
    localparam int LIMIT_W    = 7;
    localparam int GRAN_SHIFT = 22;
    localparam int CTRL_W     = LIMIT_W + 2;

    typedef struct packed {
        logic               detect_en;
        logic [LIMIT_W-1:0] limit;
        logic               hole_open;
    } ctrl_t;
endpackage

// File: rtl/wa_ctrl_reg.sv
module wa_ctrl_reg
    import wa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (we) ctrl_d = ctrl_t'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/wa_addr_check.sv
module wa_addr_check #(
    parameter int          AW        = 32,
    parameter int          LW        = 7,
    parameter int          GSHIFT    = 22,
    parameter logic [31:0] HOLE_LO   = 32'h00F0_0000,
    parameter logic [31:0] HOLE_HI   = 32'h00FF_FFFF,
    parameter logic [31:0] LEGACY_LO = 32'h000A_0000,
    parameter logic [31:0] LEGACY_HI = 32'h000F_FFFF
) (
    input  logic [AW-1:0] addr,
    input  logic [LW-1:0] limit,
    input  logic          hole_open,
    output logic          limit_ok,
    output logic          in_legacy
);
    localparam int GW = AW - GSHIFT;

    logic [GW-1:0] granule;
    logic [GW-1:0] limit_ext;
    logic          below_limit;
    logic          in_hole;

    always_comb begin
        granule     = addr[AW-1:GSHIFT];
        limit_ext   = GW'(limit);
        below_limit = (limit != '0) && (granule < limit_ext);
        in_hole     = (addr >= AW'(HOLE_LO)) && (addr <= AW'(HOLE_HI));
        in_legacy   = (addr >= AW'(LEGACY_LO)) && (addr <= AW'(LEGACY_HI));
        limit_ok    = below_limit && !(in_hole && !hole_open);
    end
endmodule

// File: rtl/wa_cycle_tracker.sv
module wa_cycle_tracker #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr_in,
    input  logic          brdy_n,
    input  logic          na_n,
    input  logic          ken_n,
    input  logic          detect_en,
    output logic [AW-1:0] addr,
    output logic          cyc_end,
    output logic          ken_now
);
    typedef struct packed {
        logic          active;
        logic          sampled;
        logic          ken;
        logic [AW-1:0] addr;
    } trk_t;

    trk_t trk_d, trk_q;
    logic strobe;
    logic sample_now;

    always_comb begin
        trk_d      = trk_q;
        strobe     = !brdy_n || !na_n;
        sample_now = trk_q.active && !trk_q.sampled && strobe;
        cyc_end    = trk_q.active && !brdy_n;
        ken_now    = trk_q.sampled ? trk_q.ken
                                   : (sample_now && detect_en && !ken_n);
        if (sample_now) begin
            trk_d.sampled = 1'b1;
            trk_d.ken     = detect_en && !ken_n;
        end
        if (cyc_end) trk_d.active = 1'b0;
        if (!trk_q.active && start) begin
            trk_d.active  = 1'b1;
            trk_d.sampled = 1'b0;
            trk_d.ken     = 1'b0;
            trk_d.addr    = addr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign addr = trk_q.addr;

    a_r7_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.active && trk_q.sampled) |=> $stable(trk_q.ken));

    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.active && start) |=> $stable(trk_q.addr));
endmodule

// File: rtl/wr_alloc_qualifier.sv
module wr_alloc_qualifier
    import wa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic              cyc_start,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              burst_rdy_n,
    input  logic              next_addr_n,
    input  logic              cache_en_n,
    output logic              alloc_permit,
    output logic              permit_valid
);
    typedef struct packed {
        logic valid;
        logic permit;
    } out_t;

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] held_addr;
    logic              cyc_end;
    logic              ken_now;
    logic              limit_ok;
    logic              in_legacy;
    out_t              out_d, out_q;

    wa_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .ctrl  (ctrl)
    );

    wa_cycle_tracker #(.AW(ADDR_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cyc_start),
        .addr_in   (cyc_addr),
        .brdy_n    (burst_rdy_n),
        .na_n      (next_addr_n),
        .ken_n     (cache_en_n),
        .detect_en (ctrl.detect_en),
        .addr      (held_addr),
        .cyc_end   (cyc_end),
        .ken_now   (ken_now)
    );

    wa_addr_check #(.AW(ADDR_W), .LW(LIMIT_W), .GSHIFT(GRAN_SHIFT)) u_chk (
        .addr      (held_addr),
        .limit     (ctrl.limit),
        .hole_open (ctrl.hole_open),
        .limit_ok  (limit_ok),
        .in_legacy (in_legacy)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = cyc_end;
        if (cyc_end) out_d.permit = !in_legacy && (limit_ok || ken_now);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign alloc_permit = out_q.permit;
    assign permit_valid = out_q.valid;

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        permit_valid |=> !permit_valid);

    a_r6_legacy_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (permit_valid && in_legacy) |-> !alloc_permit);

    a_r4_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.limit == '0) |-> !limit_ok);
endmodule

// File: tb/tb_wr_alloc_qualifier.sv
module tb_wr_alloc_qualifier;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [8:0]  cfg_wdata = '0;
    logic        cyc_start = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic        burst_rdy_n = 1'b1;
    logic        next_addr_n = 1'b1;
    logic        cache_en_n = 1'b1;
    logic        alloc_permit;
    logic        permit_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    wr_alloc_qualifier dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cyc_start(cyc_start), .cyc_addr(cyc_addr), .burst_rdy_n(burst_rdy_n),
        .next_addr_n(next_addr_n), .cache_en_n(cache_en_n),
        .alloc_permit(alloc_permit), .permit_valid(permit_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    int          m_cfg = 0;
    bit          m_busy = 0, m_smp = 0, m_kv = 0, m_valid = 0, m_permit = 0;
    longint      m_addr = 0;

    function automatic bit ref_permit(int cfg, longint addr, bit kv);
        longint lim_bytes = longint'((cfg >> 1) & 127) * 4 * 1024 * 1024;
        bit lim_ok = (lim_bytes != 0) && (addr < lim_bytes) &&
                     !(((cfg & 1) == 0) && addr >= 15*1024*1024 && addr < 16*1024*1024);
        if (addr >= 'hA0000 && addr <= 'hFFFFF) return 0;
        return lim_ok || kv;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_busy = 0; m_smp = 0; m_kv = 0; m_valid = 0; m_permit = 0;
        end else begin
            m_valid = 0;
            if (m_busy && !m_smp && (!burst_rdy_n || !next_addr_n)) begin
                m_smp = 1;
                m_kv  = (((m_cfg >> 8) & 1) == 1) && !cache_en_n;
            end
            if (m_busy && !burst_rdy_n) begin
                m_permit = ref_permit(m_cfg, m_addr, m_kv);
                m_valid  = 1;
                m_busy   = 0;
            end else if (!m_busy && cyc_start) begin
                m_busy = 1; m_smp = 0; m_kv = 0; m_addr = longint'(cyc_addr);
            end
            if (cfg_we) m_cfg = int'(cfg_wdata);
        end
    end

    // Per-clock comparison against the model (R9 timing, R8 verdict)
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (alloc_permit !== m_permit || permit_valid !== m_valid) begin
                n_bad++;
                $display("FAIL R9 per-clock: permit=%0b valid=%0b expected permit=%0b valid=%0b",
                         alloc_permit, permit_valid, m_permit, m_valid);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(string req, bit act, bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic write_cfg(logic [8:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // One write bus cycle. use_na: next-address comes first with ken_first,
    // then burst-ready arrives with ken_late. Otherwise burst-ready alone with ken_first.
    // restart: a second start with another address during the cycle.
    task automatic bus_write(logic [31:0] a, bit use_na, bit ken_first, bit ken_late,
                             bit restart, string req, bit exp);
        @(negedge clk); cyc_start = 1'b1; cyc_addr = a;
        @(negedge clk); cyc_start = 1'b0; cache_en_n = 1'b1;
        if (restart) begin
            cyc_start = 1'b1; cyc_addr = 32'h3000_0000;
            @(negedge clk); cyc_start = 1'b0;
        end
        if (use_na) begin
            next_addr_n = 1'b0; cache_en_n = !ken_first;
            @(negedge clk); next_addr_n = 1'b1;
            burst_rdy_n = 1'b0; cache_en_n = !ken_late;
        end else begin
            burst_rdy_n = 1'b0; cache_en_n = !ken_first;
        end
        @(negedge clk);
        check(req, permit_valid, 1'b1);
        check(req, alloc_permit, exp);
        burst_rdy_n = 1'b1; cache_en_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset permit", alloc_permit, 1'b0);
        check("R1 reset valid", permit_valid, 1'b0);
        rst_n = 1'b1;
        // R1: reset word has detection off and zero ceiling
        bus_write(32'h0010_0000, 0, 1, 1, 0, "R1 reset config refuses", 1'b0);

        // R2/R3: ceiling 8 -> 32 MB, hole closed
        write_cfg(9'h010);
        bus_write(32'h01FF_FFFC, 0, 0, 0, 0, "R3 just below ceiling", 1'b1);
        bus_write(32'h0200_0000, 0, 0, 0, 0, "R3 at ceiling", 1'b0);
        bus_write(32'h0000_1000, 0, 0, 0, 0, "R2 low address passes", 1'b1);
        // R5: hole closed then open
        bus_write(32'h00F8_0000, 0, 0, 0, 0, "R5 hole closed", 1'b0);
        bus_write(32'h00EF_FFFF, 0, 0, 0, 0, "R5 below hole", 1'b1);
        write_cfg(9'h011);
        bus_write(32'h00F8_0000, 0, 0, 0, 0, "R5 hole open", 1'b1);
        // R5: ceiling 3 (12 MB), hole bit ignored
        write_cfg(9'h007);
        bus_write(32'h00F0_0000, 0, 0, 0, 0, "R5 hole bit ignored below 16MB", 1'b0);
        // R4: zero ceiling with hole bit set
        write_cfg(9'h001);
        bus_write(32'h0000_1000, 0, 0, 0, 0, "R4 zero ceiling", 1'b0);

        // R6: legacy window always refused
        write_cfg(9'h1FF);
        bus_write(32'h000A_0000, 0, 1, 1, 0, "R6 window start", 1'b0);
        bus_write(32'h000F_FFFF, 1, 1, 1, 0, "R6 window end", 1'b0);
        bus_write(32'h0009_FFFF, 0, 0, 0, 0, "R6 below window", 1'b1);
        bus_write(32'h0010_0000, 0, 0, 0, 0, "R6 above window", 1'b1);

        // R7/R8: detection on, ceiling zero
        write_cfg(9'h100);
        bus_write(32'h3000_0000, 0, 1, 1, 0, "R8 cache-enable alone permits", 1'b1);
        bus_write(32'h3000_0000, 1, 1, 0, 0, "R7 sample at next-address kept", 1'b1);
        bus_write(32'h3000_0000, 1, 0, 1, 0, "R7 late assertion ignored", 1'b0);
        // R9: capture cleared between cycles
        bus_write(32'h3000_0000, 0, 1, 1, 0, "R9 capture set", 1'b1);
        bus_write(32'h3000_0000, 0, 0, 0, 0, "R9 capture cleared", 1'b0);
        // R9: verdict holds after pulse
        @(negedge clk);
        check("R9 pulse one cycle", permit_valid, 1'b0);
        check("R9 verdict held", alloc_permit, 1'b0);
        // R7: detection off ignores pin
        write_cfg(9'h000);
        bus_write(32'h3000_0000, 0, 1, 1, 0, "R7 detection off", 1'b0);

        // R10: restart ignored
        write_cfg(9'h010);
        bus_write(32'h0000_2000, 0, 0, 0, 1, "R10 restart ignored", 1'b1);

        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule